// File: doc/BRIEF.md
# Tape Control-Pulse Duty Generator

This block drives the record control track of a tape transport. Once per frame, on the rising edge of a frame reference strobe, it raises its pulse output. It drops the output again after a programmed number of prescaled clock ticks. The prescaled tick runs at half the block clock. Each frame's pulse length therefore encodes one symbol on tape. A short or a long pulse is chosen by a duty flag and one bit of a pattern register. In mark-write mode, a single fixed length is used instead.

Four 16-bit duty registers, named `dur2` to `dur5` after their slot addresses, hold the high times in ticks. A control register, a pattern register and the duty registers are written through a plain address/data write port. The mode and the selected duty value are latched at each reference edge, so reprogramming during a frame only affects the next frame. When a pulse has fully completed, a sticky interrupt flag is set on the next reference edge. Software clears it by writing one to a clear bit.

The controller has three states:
- IDLE: no pulse in flight.
- HIGH: the pulse is being driven.
- DONE: the pulse has been written and the block is waiting for the next reference edge.

Transitions:
- IDLE→HIGH (launch): a reference edge arrives with a valid, non-zero selection.
- HIGH→DONE (expire): the tick count reaches the latched value.
- DONE→HIGH (relaunch) and DONE→IDLE (report without a new pulse): taken on a reference edge. Both set the interrupt.
- HIGH→HIGH (restart) and HIGH→IDLE (abort): taken on a reference edge that arrives before expiry.
- Any state→IDLE (disable): taken when the enable bit is cleared.

Top module: `ctl_pulse_gen`

## Requirements
- R1: After reset, `pulse_out` and `irq` are 0, every register is 0, and the block is disabled.
- R2: In encoding mode (`mark_mode`=0) with duty flag (control bit 1) = 1 and pattern bit 7 = 0, the pulse is high for `dur2` × 2 clock cycles. It starts the cycle after the clock edge that sees the reference rise.
- R3: In encoding mode with duty flag = 1 and pattern bit 7 = 1, the pulse is high for `dur3` × 2 clock cycles.
- R4: In encoding mode with duty flag = 0, the pulse is high for `dur4` × 2 clock cycles when pattern bit 7 = 0, and for `dur5` × 2 clock cycles when it is 1.
- R5: In mark mode (`mark_mode`=1), the pattern bit is ignored. The pulse is high for `dur3` × 2 clock cycles when the duty flag = 0, and no pulse is produced when the duty flag = 1.
- R6: `irq` rises on the reference rising edge that follows a fully completed pulse, and only then. A frame without a pulse sets no interrupt.
- R7: `irq` stays set until a write to address 0 with data bit 3 = 1 clears it.
- R8: A selected duty value of 0 produces no pulse.
- R9: A duty register written during a frame changes the pulse only from the next reference edge on.
- R10: With the enable bit (control bit 0) at 0, `pulse_out` stays low, the tick counter is 0, and no interrupt is set.
- R11: Register addresses: 0 is control, 1 is pattern, and 2 to 5 are `dur2` to `dur5`. The prescaled tick is 2 clock cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Frame reference; the rising edge starts a frame |
| mark_mode | input | 1 | 1 selects mark-write mode, 0 selects encoding mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pulse_out | output | 1 | Record control pulse |
| irq | output | 1 | Sticky pulse-written interrupt |

## Verification
The interrupt is the hardest behaviour to reach from the ports. It depends on a pulse having fully expired in one frame and on the reference edge of the following frame. A clear write must sit between those two frames, or the flag left over from an earlier pulse would hide the result. The bench therefore runs each configuration as a pair of frames with a clear write in between. It measures the pulse width in the first frame and samples `irq` just after the second frame's reference edge. The deferred-write case is reached by issuing the register write from inside the frame loop while the pulse is still high.

// File: rtl/ctl_pulse_pkg.sv
package ctl_pulse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_DONE = 2'd2
    } pulse_st_e;

    localparam int unsigned ADDR_W      = 3;
    localparam int unsigned NUM_DUR     = 4;
    localparam int unsigned A_CTRL      = 0;
    localparam int unsigned A_PAT       = 1;
    localparam int unsigned A_DUR_FIRST = 2;

    localparam int unsigned CTRL_EN     = 0;
    localparam int unsigned CTRL_FLAG   = 1;
    localparam int unsigned CTRL_CLR    = 3;

endpackage

// File: rtl/ctl_pulse_regs.sv
module ctl_pulse_regs
    import ctl_pulse_pkg::*;
#(
    parameter int unsigned W       = 16,
    parameter int unsigned PAT_SEL = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [W-1:0]                 wr_data,
    output logic                         en,
    output logic                         flag,
    output logic                         pat_bit,
    output logic [NUM_DUR-1:0][W-1:0]    dur,
    output logic                         irq_clr
);

    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] ADR_PAT  = ADDR_W'(A_PAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            flag <= 1'b0;
        end else if (wr_en && wr_addr == ADR_CTRL) begin
            en   <= wr_data[CTRL_EN];
            flag <= wr_data[CTRL_FLAG];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_bit <= 1'b0;
        end else if (wr_en && wr_addr == ADR_PAT) begin
            pat_bit <= wr_data[PAT_SEL];
        end
    end

    for (genvar g = 0; g < NUM_DUR; g++) begin : g_dur
        localparam logic [ADDR_W-1:0] ADR_D = ADDR_W'(int'(A_DUR_FIRST) + g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dur[g] <= '0;
            end else if (wr_en && wr_addr == ADR_D) begin
                dur[g] <= wr_data;
            end
        end
    end

    assign irq_clr = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_CLR];

endmodule

// File: rtl/ctl_duty_sel.sv
module ctl_duty_sel
    import ctl_pulse_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                      mark_mode,
    input  logic                      flag,
    input  logic                      pat_bit,
    input  logic [NUM_DUR-1:0][W-1:0] dur,
    output logic [W-1:0]              sel_val,
    output logic                      allow
);

    // slot 0..3 hold dur2..dur5
    always_comb begin
        allow   = 1'b1;
        sel_val = '0;
        if (mark_mode) begin
            allow   = !flag;
            sel_val = dur[1];
        end else if (flag) begin
            sel_val = pat_bit ? dur[1] : dur[0];
        end else begin
            sel_val = pat_bit ? dur[3] : dur[2];
        end
    end

endmodule

// File: rtl/ctl_pulse_fsm.sv
module ctl_pulse_fsm
    import ctl_pulse_pkg::*;
#(
    parameter int unsigned W        = 16,
    parameter int unsigned PRESCALE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ref_in,
    input  logic         allow,
    input  logic [W-1:0] sel_val,
    input  logic         irq_clr,
    output logic         pulse_out,
    output logic         irq,
    output logic [W-1:0] cnt,
    output logic [W-1:0] dur_q
);

    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    pulse_st_e     state, nxt;
    logic          ref_q;
    logic          ref_edge;
    logic          launch;
    logic          tick;
    logic [PW-1:0] pre;
    logic [W-1:0]  cnt_inc;

    assign ref_edge = ref_in && !ref_q;
    assign launch   = en && ref_edge && allow && (sel_val != '0);
    assign tick     = (pre == PRE_LAST);
    assign cnt_inc  = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_in;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (!en)                          nxt = ST_IDLE;
                else if (ref_edge)                nxt = launch ? ST_HIGH : ST_IDLE;
                else if (tick && cnt_inc == dur_q) nxt = ST_DONE;
            end
            ST_DONE: begin
                if (!en)           nxt = ST_IDLE;
                else if (ref_edge) nxt = launch ? ST_HIGH : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // tick prescaler and high-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre   <= '0;
            cnt   <= '0;
            dur_q <= '0;
        end else if (!en) begin
            pre <= '0;
            cnt <= '0;
        end else if (launch) begin
            pre   <= '0;
            cnt   <= '0;
            dur_q <= sel_val;
        end else if (state == ST_HIGH) begin
            if (tick) begin
                pre <= '0;
                cnt <= cnt_inc;
            end else begin
                pre <= pre + 1'b1;
            end
        end else begin
            pre <= '0;
            cnt <= '0;
        end
    end

    // sticky interrupt
    always_ff @(posedge clk) begin
        if (!rst_n)                                  irq <= 1'b0;
        else if (en && ref_edge && state == ST_DONE) irq <= 1'b1;
        else if (irq_clr)                            irq <= 1'b0;
    end

    // outputs
    always_comb begin
        pulse_out = (state == ST_HIGH);
    end

endmodule

// File: rtl/ctl_pulse_gen.sv
module ctl_pulse_gen
    import ctl_pulse_pkg::*;
#(
    parameter int unsigned DUTY_W   = 16,
    parameter int unsigned PRESCALE = 2,
    parameter int unsigned PAT_SEL  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              mark_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic              pulse_out,
    output logic              irq
);

    logic                           en;
    logic                           duty_flag;
    logic                           pat_bit;
    logic [NUM_DUR-1:0][DUTY_W-1:0] dur;
    logic                           irq_clr;
    logic [DUTY_W-1:0]              sel_val;
    logic                           allow;
    logic [DUTY_W-1:0]              tick_cnt;
    logic [DUTY_W-1:0]              duty_q;

    ctl_pulse_regs #(.W(DUTY_W), .PAT_SEL(PAT_SEL)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en      (en),
        .flag    (duty_flag),
        .pat_bit (pat_bit),
        .dur     (dur),
        .irq_clr (irq_clr)
    );

    ctl_duty_sel #(.W(DUTY_W)) sel_i (
        .mark_mode (mark_mode),
        .flag      (duty_flag),
        .pat_bit   (pat_bit),
        .dur       (dur),
        .sel_val   (sel_val),
        .allow     (allow)
    );

    ctl_pulse_fsm #(.W(DUTY_W), .PRESCALE(PRESCALE)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ref_in    (ref_in),
        .allow     (allow),
        .sel_val   (sel_val),
        .irq_clr   (irq_clr),
        .pulse_out (pulse_out),
        .irq       (irq),
        .cnt       (tick_cnt),
        .dur_q     (duty_q)
    );

endmodule

// File: rtl/ctl_pulse_gen_chk.sv
module ctl_pulse_gen_chk
    import ctl_pulse_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_in,
    input logic              mark_mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic              pulse_out,
    input logic              irq,
    input logic              en,
    input logic              duty_flag,
    input logic [W-1:0]      tick_cnt,
    input logic [W-1:0]      duty_q
);

    logic ref_prev;
    logic clr_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev <= 1'b0;
        else        ref_prev <= ref_in;
    end

    assign clr_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL)) && wr_data[CTRL_CLR];

    p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse_out);

    p_off_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tick_cnt == '0));

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    p_irq_on_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ref_in) && !$past(ref_prev)));

    p_zero_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> (duty_q != '0));

    p_mark_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> !($past(mark_mode) && $past(duty_flag)));

    p_start_on_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> ($past(ref_in) && !$past(ref_prev)));

endmodule

bind ctl_pulse_gen ctl_pulse_gen_chk #(.W(DUTY_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .mark_mode (mark_mode),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pulse_out (pulse_out),
    .irq       (irq),
    .en        (en),
    .duty_flag (duty_flag),
    .tick_cnt  (tick_cnt),
    .duty_q    (duty_q)
);

// File: tb/ctl_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module ctl_pulse_gen_tb_top;

    localparam int P     = 2;
    localparam int FRAME = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        mark_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pulse_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ctl_pulse_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .mark_mode (mark_mode),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one reference frame; optional register write while the pulse is high
    task automatic run_frame(output int width, output int irq0,
                             input bit mid, input logic [2:0] ma, input logic [15:0] md);
        @(negedge clk);
        ref_in = 1'b1;
        @(posedge clk);
        width = 0;
        irq0  = 0;
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            if (i == 0) begin
                irq0   = int'(irq);
                ref_in = 1'b0;
            end
            if (pulse_out) width++;
            if (mid && i == 2) begin
                wr_en = 1'b1; wr_addr = ma; wr_data = md;
            end else begin
                wr_en = 1'b0;
            end
        end
    endtask

    function automatic int exp_w(input bit mk, input bit fl, input bit pt,
                                 input int d2, input int d3, input int d4, input int d5);
        if (mk) return fl ? 0 : d3 * P;
        if (fl) return (pt ? d3 : d2) * P;
        return (pt ? d5 : d4) * P;
    endfunction

    function automatic string req_of(input bit mk, input bit fl, input bit pt);
        if (mk)       return "R5";
        if (fl && !pt) return "R2";
        if (fl)       return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int w, q, wb;
        logic [15:0] ctrl;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "pulse after reset", int'(pulse_out), 0);
        check("R1", "irq after reset", int'(irq), 0);
        // R10 disabled after reset, duties loaded (R11 addresses)
        wr(3'd2, 16'd3); wr(3'd3, 16'd5); wr(3'd4, 16'd7); wr(3'd5, 16'd9);
        wr(3'd1, 16'h0000);
        run_frame(w, q, 1'b0, '0, '0);
        check("R10", "width while disabled", w, 0);
        run_frame(w, q, 1'b0, '0, '0);
        check("R10", "irq while disabled", q, 0);

        // sweep mode x flag x pattern bit
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int p = 0; p < 2; p++) begin
                    mark_mode = m[0];
                    ctrl = 16'h0001 | (f[0] ? 16'h0002 : 16'h0000);
                    wr(3'd0, ctrl);
                    wr(3'd1, p[0] ? 16'h0080 : 16'h007F);
                    run_frame(w, q, 1'b0, '0, '0);
                    check(req_of(m[0], f[0], p[0]), "pulse width", w,
                          exp_w(m[0], f[0], p[0], 3, 5, 7, 9));
                    wr(3'd0, ctrl | 16'h0008);
                    run_frame(wb, q, 1'b0, '0, '0);
                    check("R6", "irq after frame", q, (w > 0) ? 1 : 0);
                end
            end
        end

        // duty value sweep on dur2 (R2, R8 at zero)
        mark_mode = 1'b0;
        ctrl = 16'h0003;
        wr(3'd0, ctrl);
        wr(3'd1, 16'h0000);
        for (int v = 0; v <= 12; v++) begin
            wr(3'd2, 16'(v));
            run_frame(w, q, 1'b0, '0, '0);
            check((v == 0) ? "R8" : "R2", "swept width", w, v * P);
            wr(3'd0, ctrl | 16'h0008);
            run_frame(wb, q, 1'b0, '0, '0);
            check("R6", "irq after swept frame", q, (v > 0) ? 1 : 0);
        end

        // R9 mid-frame write deferred
        wr(3'd2, 16'd4);
        run_frame(w, q, 1'b1, 3'd2, 16'd10);
        check("R9", "width with mid-frame write", w, 8);
        run_frame(w, q, 1'b0, '0, '0);
        check("R9", "width next frame", w, 20);

        // R7 sticky and clear
        run_frame(w, q, 1'b0, '0, '0);
        check("R7", "irq set", int'(irq), 1);
        repeat (15) @(negedge clk);
        check("R7", "irq still set", int'(irq), 1);
        wr(3'd0, ctrl);
        check("R7", "irq kept by write without clear bit", int'(irq), 1);
        wr(3'd0, ctrl | 16'h0008);
        check("R7", "irq cleared", int'(irq), 0);

        // R10 disable: no pulse, no irq
        wr(3'd0, 16'h0000);
        run_frame(w, q, 1'b0, '0, '0);
        check("R10", "width after disable", w, 0);
        check("R10", "irq after disable frame", int'(irq), 0);
        run_frame(w, q, 1'b0, '0, '0);
        check("R10", "irq next disabled frame", q, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule